// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two table entries from memory, one after the other. A client starts a walk with a valid/ready request that carries the virtual address. When the request is accepted, the block also samples a page-size select (4 KB or 8 KB minimum page) and the table-base register value. The block then issues a first-level read and, if that entry is present, a second-level read over a single-outstanding request/response memory port. It finishes with a one-cycle completion pulse that carries a fault flag and, when there is no fault, the translated physical address.

The two entry types use opposite polarities for their bit 0. A first-level entry with bit 0 set is absent. A second-level entry with bit 0 clear is invalid. The index fields, their shifts and the masks that keep the next-level base all change with the selected page size. The block runs one walk at a time and has no caching.

Top module: `xlat_walker`

## Requirements
- R1: `req_ready` is high only when no walk is in progress. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The virtual address, `cfg_page_8k` and `cfg_tbl_base` are sampled at that edge. Later changes to these inputs have no effect on the walk.
- R2: With `cfg_page_8k`=0 (4 KB), the first read address is `(tbl_base & 0xFFFFF000) | ((va & 0xFFC00000) >> 20)`.
- R3: With `cfg_page_8k`=1 (8 KB), the first read address is `(tbl_base & 0xFFFFF000) | ((va & 0xFF000000) >> 22)`.
- R4: Once `mem_rd_req` is raised, it stays high and `mem_rd_addr` stays unchanged until the cycle in which `mem_rd_ack` is high.
- R5: If bit 0 of the first-level entry is 1, the walk ends with `fault`=1 and no second read is issued.
- R6: In 4 KB mode, the second read address is `(l1_entry & 0xFFFFF000) | ((va & 0x003FF000) >> 10)`.
- R7: In 8 KB mode, the second read address is `(l1_entry & 0xFFFFE000) | ((va & 0x00FFE000) >> 11)`.
- R8: If bit 0 of the second-level entry is 0, the walk ends with `fault`=1. If that bit is 1, the walk ends with `fault`=0.
- R9: In 4 KB mode, a successful walk returns `paddr` = `(l2_entry & 0xFFFFF000) | (va & 0x00000FFF)`.
- R10: In 8 KB mode, a successful walk returns `paddr` = `(l2_entry & 0xFFFFE000) | (va & 0x00001FFF)`.
- R11: `done` is high for exactly one cycle per walk. `fault` is high only while `done` is high.
- R12: Only one read is outstanding at a time. After an acknowledged request, `mem_rd_req` stays low until the matching `mem_rd_dvalid` pulse.
- R13: While `rst_n` is low and right after it, `done`, `fault` and `mem_rd_req` are low, and `paddr` and `mem_rd_addr` are zero. After reset, `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Block idle and able to accept a walk |
| req_vaddr | input | 32 | Virtual address to translate |
| cfg_page_8k | input | 1 | Page size select: 0 = 4 KB, 1 = 8 KB |
| cfg_tbl_base | input | 32 | First-level table base register value |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Physical byte address of the 4-byte entry |
| mem_rd_ack | input | 1 | Memory accepted the read request |
| mem_rd_dvalid | input | 1 | Read data valid pulse |
| mem_rd_data | input | 32 | Read data (table entry) |
| done | output | 1 | One-cycle walk completion pulse |
| fault | output | 1 | Walk failed; valid with `done` |
| paddr | output | 32 | Translated physical address; valid with `done` when `fault` is low |

## Verification
A walker in the wrong phase shows at the memory port within one or two cycles. It might issue a second-level read after an absent first-level entry, request again while a read is still outstanding, or present an address built with the wrong page size. The scoreboard catches each of these when the read request appears, because it compares every address with a queue of expected reads, and an unexpected extra read finds that queue empty. A wrong latched field or a wrong fault decision shows one cycle after the last read response, when the `done` pulse carries the wrong `fault` or `paddr`. Stimulus that keeps changing the request inputs during a walk shows any failure to sample those inputs at acceptance.

// File: rtl/xlat_pkg.sv
// Package: shared types and page-size geometry for the table walker.
// Assumes size index 0 is the smallest page; each larger index doubles the page.
package xlat_pkg;

    // Walk phases of the controller.
    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_LVL1 = 2'd1,
        WS_LVL2 = 2'd2,
        WS_FIN  = 2'd3
    } walk_st_e;

    // Number of selectable minimum page sizes.
    localparam int NUM_PG_SIZES = 2;

    // Page offset width for a given size index (12 = 4 KB).
    function automatic int pg_shift(input int idx);
        return 12 + idx;
    endfunction

    // Second-level index width for a given size index.
    function automatic int l2_idx_bits(input int idx);
        return 10 + idx;
    endfunction

endpackage

// File: rtl/xlat_addr_gen.sv
// Module: address formation for a single page-size variant.
// Forms the first-level entry address, the second-level entry address and the
// final physical address with pure combinational logic. Entries are
// 2**ENT_SHIFT bytes wide, and the first-level table is aligned to 2**TBL_ALIGN bytes.
module xlat_addr_gen #(
    parameter int AW        = 32,
    parameter int PG_SHIFT  = 12,
    parameter int L2_BITS   = 10,
    parameter int TBL_ALIGN = 12,
    parameter int ENT_SHIFT = 2
) (
    input  logic [AW-1:0] va,
    input  logic [AW-1:0] tbl_base,
    input  logic [AW-1:0] l1_entry,
    input  logic [AW-1:0] l2_entry,
    output logic [AW-1:0] l1_addr,
    output logic [AW-1:0] l2_addr,
    output logic [AW-1:0] pa
);
    localparam int          L1_LSB   = PG_SHIFT + L2_BITS;
    localparam logic [AW-1:0] PG_MASK  = (AW'(1) << PG_SHIFT) - AW'(1);
    localparam logic [AW-1:0] TBL_MASK = (AW'(1) << TBL_ALIGN) - AW'(1);
    localparam logic [AW-1:0] IDX_MASK = (AW'(1) << L2_BITS) - AW'(1);

    // First level: aligned base plus the upper VA field as an entry index.
    assign l1_addr = (tbl_base & ~TBL_MASK) | ((va >> L1_LSB) << ENT_SHIFT);

    // Second level: page-aligned table pointer plus the middle VA field.
    assign l2_addr = (l1_entry & ~PG_MASK) | (((va >> PG_SHIFT) & IDX_MASK) << ENT_SHIFT);

    // Physical address: frame number from the leaf entry plus the page offset.
    assign pa = (l2_entry & ~PG_MASK) | (va & PG_MASK);

endmodule

// File: rtl/xlat_addr_sel.sv
// Module: builds one address generator per page size and selects one.
// Assumes size_sel is below NUM_SZ; any larger value falls back to index 0.
module xlat_addr_sel #(
    parameter int AW     = 32,
    parameter int NUM_SZ = xlat_pkg::NUM_PG_SIZES,
    parameter int SZ_W   = (NUM_SZ > 1) ? $clog2(NUM_SZ) : 1
) (
    input  logic [SZ_W-1:0] size_sel,
    input  logic [AW-1:0]   va,
    input  logic [AW-1:0]   tbl_base,
    input  logic [AW-1:0]   l1_entry,
    input  logic [AW-1:0]   l2_entry,
    output logic [AW-1:0]   l1_addr,
    output logic [AW-1:0]   l2_addr,
    output logic [AW-1:0]   pa
);
    logic [AW-1:0] l1_v [NUM_SZ];
    logic [AW-1:0] l2_v [NUM_SZ];
    logic [AW-1:0] pa_v [NUM_SZ];

    for (genvar g = 0; g < NUM_SZ; g++) begin : g_size
        xlat_addr_gen #(
            .AW        (AW),
            .PG_SHIFT  (xlat_pkg::pg_shift(g)),
            .L2_BITS   (xlat_pkg::l2_idx_bits(g)),
            .TBL_ALIGN (12),
            .ENT_SHIFT (2)
        ) u_gen (
            .va       (va),
            .tbl_base (tbl_base),
            .l1_entry (l1_entry),
            .l2_entry (l2_entry),
            .l1_addr  (l1_v[g]),
            .l2_addr  (l2_v[g]),
            .pa       (pa_v[g])
        );
    end

    // Pick the variant that matches the latched page size.
    always_comb begin
        l1_addr = l1_v[0];
        l2_addr = l2_v[0];
        pa      = pa_v[0];
        for (int i = 1; i < NUM_SZ; i++) begin
            if (int'(size_sel) == i) begin
                l1_addr = l1_v[i];
                l2_addr = l2_v[i];
                pa      = pa_v[i];
            end
        end
    end

endmodule

// File: rtl/xlat_walk_ctl.sv
// Module: walk sequencer. Accepts one request when idle and latches its inputs.
// Issues the level-1 read and then the level-2 read, with one read outstanding
// at a time, and reports the result with a one-cycle done pulse.
// Assumes mem_rd_dvalid comes at least one cycle after the matching mem_rd_ack.
module xlat_walk_ctl #(
    parameter int AW   = 32,
    parameter int SZ_W = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [AW-1:0]   req_vaddr,
    input  logic [SZ_W-1:0] cfg_size,
    input  logic [AW-1:0]   cfg_base,
    output logic            mem_rd_req,
    output logic [AW-1:0]   mem_rd_addr,
    input  logic            mem_rd_ack,
    input  logic            mem_rd_dvalid,
    input  logic [AW-1:0]   mem_rd_data,
    output logic            done,
    output logic            fault,
    output logic [AW-1:0]   paddr,
    output logic [AW-1:0]   va_q,
    output logic [AW-1:0]   base_q,
    output logic [AW-1:0]   l1e_q,
    output logic [SZ_W-1:0] size_q,
    input  logic [AW-1:0]   l1_addr,
    input  logic [AW-1:0]   l2_addr,
    input  logic [AW-1:0]   pa_calc
);
    import xlat_pkg::*;

    walk_st_e      st_q;
    logic          pend_q;
    logic          fault_q;
    logic [AW-1:0] paddr_q;

    // Sequencer state, latched request fields and the result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= WS_IDLE;
            pend_q  <= 1'b0;
            fault_q <= 1'b0;
            paddr_q <= '0;
            va_q    <= '0;
            base_q  <= '0;
            l1e_q   <= '0;
            size_q  <= '0;
        end else begin
            unique case (st_q)
                WS_IDLE: begin
                    fault_q <= 1'b0;
                    pend_q  <= 1'b0;
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        base_q  <= cfg_base;
                        size_q  <= cfg_size;
                        paddr_q <= '0;
                        st_q    <= WS_LVL1;
                    end
                end
                WS_LVL1: begin
                    if (!pend_q && mem_rd_ack) begin
                        pend_q <= 1'b1;
                    end else if (pend_q && mem_rd_dvalid) begin
                        pend_q <= 1'b0;
                        if (mem_rd_data[0]) begin
                            fault_q <= 1'b1;
                            st_q    <= WS_FIN;
                        end else begin
                            l1e_q <= mem_rd_data;
                            st_q  <= WS_LVL2;
                        end
                    end
                end
                WS_LVL2: begin
                    if (!pend_q && mem_rd_ack) begin
                        pend_q <= 1'b1;
                    end else if (pend_q && mem_rd_dvalid) begin
                        pend_q <= 1'b0;
                        st_q   <= WS_FIN;
                        if (!mem_rd_data[0]) begin
                            fault_q <= 1'b1;
                        end else begin
                            paddr_q <= pa_calc;
                        end
                    end
                end
                WS_FIN: begin
                    st_q <= WS_IDLE;
                end
                default: st_q <= WS_IDLE;
            endcase
        end
    end

    // Port outputs decoded from the phase; the address is zero when no read is requested.
    always_comb begin
        req_ready   = (st_q == WS_IDLE);
        mem_rd_req  = ((st_q == WS_LVL1) || (st_q == WS_LVL2)) && !pend_q;
        mem_rd_addr = '0;
        if (mem_rd_req) begin
            mem_rd_addr = (st_q == WS_LVL2) ? l2_addr : l1_addr;
        end
        done  = (st_q == WS_FIN);
        fault = done && fault_q;
        paddr = paddr_q;
    end

endmodule

// File: rtl/xlat_walker.sv
// Module: top of the two-level page table walker.
// Connects the walk sequencer to the page-size address generators. The
// second-level entry goes straight from the read data to the physical address
// logic, so no register holds it.
module xlat_walker #(
    parameter int AW     = 32,
    parameter int NUM_SZ = xlat_pkg::NUM_PG_SIZES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_vaddr,
    input  logic          cfg_page_8k,
    input  logic [AW-1:0] cfg_tbl_base,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_ack,
    input  logic          mem_rd_dvalid,
    input  logic [AW-1:0] mem_rd_data,
    output logic          done,
    output logic          fault,
    output logic [AW-1:0] paddr
);
    localparam int SZ_W = (NUM_SZ > 1) ? $clog2(NUM_SZ) : 1;

    logic [AW-1:0]   va_q, base_q, l1e_q;
    logic [SZ_W-1:0] size_q;
    logic [AW-1:0]   l1_addr, l2_addr, pa_calc;
    logic [SZ_W-1:0] cfg_size;

    assign cfg_size = SZ_W'(cfg_page_8k);

    xlat_walk_ctl #(.AW(AW), .SZ_W(SZ_W)) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .cfg_size      (cfg_size),
        .cfg_base      (cfg_tbl_base),
        .mem_rd_req    (mem_rd_req),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rd_ack    (mem_rd_ack),
        .mem_rd_dvalid (mem_rd_dvalid),
        .mem_rd_data   (mem_rd_data),
        .done          (done),
        .fault         (fault),
        .paddr         (paddr),
        .va_q          (va_q),
        .base_q        (base_q),
        .l1e_q         (l1e_q),
        .size_q        (size_q),
        .l1_addr       (l1_addr),
        .l2_addr       (l2_addr),
        .pa_calc       (pa_calc)
    );

    xlat_addr_sel #(.AW(AW), .NUM_SZ(NUM_SZ), .SZ_W(SZ_W)) u_sel (
        .size_sel (size_q),
        .va       (va_q),
        .tbl_base (base_q),
        .l1_entry (l1e_q),
        .l2_entry (mem_rd_data),
        .l1_addr  (l1_addr),
        .l2_addr  (l2_addr),
        .pa       (pa_calc)
    );

endmodule

// File: rtl/xlat_walker_chk.sv
// Module: port-level protocol and result checker for xlat_walker.
// Tracks the outstanding read and the entry bits seen in each walk using only
// port signals, and checks them against the completion outputs.
module xlat_walker_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_vaddr,
    input logic          mem_rd_req,
    input logic [AW-1:0] mem_rd_addr,
    input logic          mem_rd_ack,
    input logic          mem_rd_dvalid,
    input logic [AW-1:0] mem_rd_data,
    input logic          done,
    input logic          fault,
    input logic [AW-1:0] paddr
);
    logic          out_q;
    logic [1:0]    resp_cnt;
    logic          l1_np;
    logic          l2_ok;
    logic [AW-1:0] va_c;

    // Observer state: outstanding read, responses per walk, entry bit 0 values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q    <= 1'b0;
            resp_cnt <= '0;
            l1_np    <= 1'b0;
            l2_ok    <= 1'b0;
            va_c     <= '0;
        end else begin
            if (mem_rd_req && mem_rd_ack) out_q <= 1'b1;
            else if (mem_rd_dvalid)       out_q <= 1'b0;
            if (req_valid && req_ready) begin
                resp_cnt <= '0;
                l1_np    <= 1'b0;
                l2_ok    <= 1'b0;
                va_c     <= req_vaddr;
            end else if (mem_rd_dvalid) begin
                resp_cnt <= resp_cnt + 2'd1;
                if (resp_cnt == 2'd0) l1_np <= mem_rd_data[0];
                else                  l2_ok <= mem_rd_data[0];
            end
        end
    end

    a_r1_accept_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_rd_addr));

    a_r5_l1_absent_faults: assert property (@(posedge clk) disable iff (!rst_n)
        done && l1_np |-> fault && (resp_cnt == 2'd1));

    a_r8_l2_invalid_faults: assert property (@(posedge clk) disable iff (!rst_n)
        done && (resp_cnt == 2'd2) && !l2_ok |-> fault);

    a_r8_l2_valid_passes: assert property (@(posedge clk) disable iff (!rst_n)
        done && (resp_cnt == 2'd2) && l2_ok |-> !fault);

    a_r9_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fault |-> paddr[11:0] == va_c[11:0]);

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);

    a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        out_q |-> !mem_rd_req);

endmodule

bind xlat_walker xlat_walker_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .mem_rd_req    (mem_rd_req),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rd_ack    (mem_rd_ack),
    .mem_rd_dvalid (mem_rd_dvalid),
    .mem_rd_data   (mem_rd_data),
    .done          (done),
    .fault         (fault),
    .paddr         (paddr)
);

// File: tb/test_xlat_walker.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected reads and results, the memory
// responder checks each read address, and the monitor checks each completion.
module test_xlat_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        cfg_page_8k = 1'b0;
    logic [31:0] cfg_tbl_base = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic        mem_rd_dvalid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        done;
    logic        fault;
    logic [31:0] paddr;

    always #4 clk = ~clk;

    xlat_walker i_xlat_walker (.*);

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] mem [logic [31:0]];
    logic [31:0] addr_q [$];
    string       atag_q [$];
    logic        flt_q  [$];
    logic [31:0] pa_q   [$];
    string       rtag_q [$];
    int          dly = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_l1(input logic [31:0] va, input logic big, input logic [31:0] base);
        return big ? ((base & 32'hFFFFF000) | ((va & 32'hFF000000) >> 22))
                   : ((base & 32'hFFFFF000) | ((va & 32'hFFC00000) >> 20));
    endfunction

    function automatic logic [31:0] exp_l2(input logic [31:0] va, input logic big, input logic [31:0] e);
        return big ? ((e & 32'hFFFFE000) | ((va & 32'h00FFE000) >> 11))
                   : ((e & 32'hFFFFF000) | ((va & 32'h003FF000) >> 10));
    endfunction

    function automatic logic [31:0] exp_pa(input logic [31:0] va, input logic big, input logic [31:0] e);
        return big ? ((e & 32'hFFFFE000) | (va & 32'h00001FFF))
                   : ((e & 32'hFFFFF000) | (va & 32'h00000FFF));
    endfunction

    // Driver: loads the table entries, queues expectations and issues one walk (R1).
    task automatic walk(input logic [31:0] va, input logic big, input logic [31:0] base,
                        input logic [31:0] l1e, input logic [31:0] l2e,
                        input string t1, input string t2, input string tr);
        logic [31:0] a1, a2;
        logic        flt;
        a1 = exp_l1(va, big, base);
        mem[a1] = l1e;
        addr_q.push_back(a1); atag_q.push_back(t1);
        if (!l1e[0]) begin
            a2 = exp_l2(va, big, l1e);
            mem[a2] = l2e;
            addr_q.push_back(a2); atag_q.push_back(t2);
        end
        flt = l1e[0] | ~l2e[0];
        flt_q.push_back(flt);
        pa_q.push_back(flt ? 32'h0 : exp_pa(va, big, l2e));
        rtag_q.push_back(tr);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; cfg_page_8k = big; cfg_tbl_base = base;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R1 busy after accept", 32'(req_ready), 32'h0);
        // R1: scramble the request inputs during the walk; the result must not change.
        req_vaddr = ~va; cfg_page_8k = ~big; cfg_tbl_base = ~base;
        while (!done) @(negedge clk);
        @(negedge clk);
        check(!done, "R11 done one cycle", 32'(done), 32'h0);
    endtask

    // Memory responder: checks each read address, then acks and returns data after a delay.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_rd_req) begin
                logic [31:0] a, ea;
                string       t;
                a = mem_rd_addr;
                if (addr_q.size() == 0) begin
                    check(1'b0, "R5 unexpected read", a, 32'h0);
                    ea = a; t = "R5";
                end else begin
                    ea = addr_q.pop_front(); t = atag_q.pop_front();
                    check(a == ea, t, a, ea);
                end
                for (int k = 0; k < dly; k++) begin
                    @(negedge clk);
                    check(mem_rd_req && mem_rd_addr == a, "R4 request held", mem_rd_addr, a);
                end
                mem_rd_ack = 1'b1;
                @(negedge clk);
                mem_rd_ack = 1'b0;
                for (int k = 0; k < dly; k++) begin
                    check(!mem_rd_req, "R12 one outstanding", 32'(mem_rd_req), 32'h0);
                    @(negedge clk);
                end
                check(!mem_rd_req, "R12 one outstanding", 32'(mem_rd_req), 32'h0);
                mem_rd_dvalid = 1'b1;
                mem_rd_data = mem.exists(a) ? mem[a] : 32'h0;
                @(negedge clk);
                mem_rd_dvalid = 1'b0;
                mem_rd_data = '0;
                dly = (dly + 1) % 4;
            end
        end
    end

    // Monitor: pops the expected result on each completion pulse and compares it.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (flt_q.size() == 0) begin
                check(1'b0, "R11 unexpected done", 32'(done), 32'h0);
            end else begin
                logic        ef;
                logic [31:0] ep;
                string       t;
                ef = flt_q.pop_front(); ep = pa_q.pop_front(); t = rtag_q.pop_front();
                check(fault == ef, {t, " fault"}, 32'(fault), 32'(ef));
                if (!ef) check(paddr == ep, {t, " paddr"}, paddr, ep);
            end
        end
        if (rst_n && !done) check(!fault, "R11 fault only with done", 32'(fault), 32'h0);
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog: a hung walk counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog actual=no_completion expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!done && !fault && !mem_rd_req, "R13 outputs low in reset", {29'h0, done, fault, mem_rd_req}, 32'h0);
        check(paddr == 32'h0 && mem_rd_addr == 32'h0, "R13 zero buses in reset", paddr | mem_rd_addr, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready, "R13 ready after reset", 32'(req_ready), 32'h1);
        check(!done && !mem_rd_req, "R13 idle after reset", {30'h0, done, mem_rd_req}, 32'h0);

        walk(32'h1234_5678, 1'b0, 32'h0010_0000, 32'h0020_0000, 32'hABCD_E001, "R2", "R6", "R9 R8");
        walk(32'hFEDC_BA98, 1'b1, 32'h0030_0ABC, 32'h0040_1FFE, 32'h1357_9BDF, "R3", "R7", "R10 R8");
        walk(32'h8000_1FFF, 1'b0, 32'h00A0_0FFF, 32'h0050_0001, 32'h0, "R2", "R6", "R5");
        walk(32'h4321_0ABC, 1'b1, 32'h00B0_0000, 32'h0060_0000, 32'h7777_6000, "R3", "R7", "R8");
        walk(32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFF, 32'h0070_0FFE, 32'hFFFF_FFFF, "R2", "R6", "R9");
        walk(32'h0000_0000, 1'b1, 32'h0000_0000, 32'h0090_0000, 32'h2468_0001, "R3", "R7", "R10");
        walk(32'hFFFF_FFFF, 1'b1, 32'h00C0_0000, 32'h0080_1FFF, 32'h0, "R3", "R7", "R5");
        walk(32'h0ABC_DEF0, 1'b0, 32'h00D0_0000, 32'h00E0_0000, 32'h0000_0FFE, "R2", "R6", "R8");
        walk(32'h7FFF_E123, 1'b1, 32'h00F0_0000, 32'h0110_0000, 32'hCAFE_3FFF, "R3", "R7", "R10");

        repeat (5) @(negedge clk);
        check(addr_q.size() == 0, "R5 all reads consumed", 32'(addr_q.size()), 32'h0);
        check(flt_q.size() == 0, "R11 all walks completed", 32'(flt_q.size()), 32'h0);
        summary();
        $finish;
    end

endmodule